// File: doc/BRIEF.md
# Media element ALU

This block computes one integer element operation for media kernels. It has four operations: rounding average, absolute difference, minimum and maximum. Each operation can treat its operands as signed or unsigned. A width select, set at run time, picks an element of 8, 16 or 32 bits. The element is taken from the low bits of each 32-bit operand word, and any bits above it are ignored. The result comes back in the low bits of a 32-bit word, with the unused upper bits forced to zero.

When the caller sets the record flag, the block also returns a 4-bit condition field. For minimum and maximum, this field describes how the two inputs compare: it tells whether b − a is negative, positive or zero. It does not describe the value that was returned. For average and absolute difference, the field describes the truncated result.

A build parameter decides how the output is presented. By default the output is registered, giving one cycle of latency. The output can also be taken straight from the logic.

Top module: `media_elem_alu`

## Requirements
- R1: With opcode 0 (average), the result is floor((a + b + 1) / 2) truncated to the element width. The sum keeps its carry, so for example 8-bit unsigned 0xFF and 0xFF give 0xFF. Signed averaging uses sign-extended operands.
- R2: With opcode 1 (absolute difference), the result is a − b when a > b and b − a otherwise, truncated to the element width.
- R3: With opcode 2 (minimum), the result is a when a < b and b otherwise.
- R4: With opcode 3 (maximum), the result is a when a > b and b otherwise.
- R5: When signed_i is 1, elements are compared and extended as two's complement; when it is 0, they are unsigned. width_i selects the element width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Operand bits above the element width have no effect.
- R6: Result bits above the selected element width are always zero.
- R7: When rec_i is 0, cond_o is 0000.
- R8: For minimum and maximum with rec_i set, the bits of cond_o are assigned as follows. Bit 3 is set when b < a, bit 2 when b > a, and bit 1 when a equals b. The comparison is made at the element width and uses the selected signedness.
- R9: For average and absolute difference with rec_i set, the bits of cond_o are assigned as follows. Bit 3 is set when signed_i is 1 and the top element bit of the result is 1. Bit 1 is set when the result is zero. Bit 2 is set in every other case.
- R10: cond_o bit 0 is always 0. When rec_i is set, exactly one of bits 3 to 1 is set.
- R11: With REG_OUT = 1, the outputs show the operation applied one clock earlier. While rst_n is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a_i | input | 32 | Operand a, element in the low bits |
| op_b_i | input | 32 | Operand b, element in the low bits |
| opcode_i | input | 2 | 0 average, 1 absolute difference, 2 minimum, 3 maximum |
| signed_i | input | 1 | 1 selects signed arithmetic |
| width_i | input | 2 | Element width select |
| rec_i | input | 1 | Record flag enabling the condition field |
| result_o | output | 32 | Element result, zero above the element width |
| cond_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions assume that every control input is a known value on each clock edge once reset has been released. This holds because the bench drives all inputs at the falling edge, and only from tasks. The min/max selection check assumes the operands are masked at the width held in the same cycle. The stimulus therefore never changes width_i between an operation and the edge that captures it. Both random and directed vectors cover all four width codes, so the reserved code 3 is exercised as a 32-bit element.

// File: rtl/mea_pkg.sv
package mea_pkg;

   typedef enum logic [1:0] {
      OP_AVG  = 2'd0,
      OP_ABSD = 2'd1,
      OP_MIN  = 2'd2,
      OP_MAX  = 2'd3
   } mea_op_e;

   typedef enum logic [1:0] {
      EW_QTR  = 2'd0,
      EW_HALF = 2'd1,
      EW_FULL = 2'd2,
      EW_RSV  = 2'd3
   } mea_ew_e;

   localparam int COND_W = 4;

endpackage

// File: rtl/mea_operand.sv
module mea_operand
   import mea_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] raw_i,
   input  mea_ew_e           ew_i,
   input  logic              sgn_i,
   output logic [DATA_W:0]   ext_o
);
   localparam int QW = DATA_W / 4;
   localparam int HW = DATA_W / 2;

   logic qsign, hsign, fsign;

   assign qsign = sgn_i & raw_i[QW-1];
   assign hsign = sgn_i & raw_i[HW-1];
   assign fsign = sgn_i & raw_i[DATA_W-1];

   always_comb begin
      case (ew_i)
         EW_QTR:  ext_o = {{(DATA_W-QW+1){qsign}}, raw_i[QW-1:0]};
         EW_HALF: ext_o = {{(DATA_W-HW+1){hsign}}, raw_i[HW-1:0]};
         default: ext_o = {fsign, raw_i};
      endcase
   end
endmodule

// File: rtl/mea_arith.sv
module mea_arith
   import mea_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W:0]   ea_i,
   input  logic [DATA_W:0]   eb_i,
   input  mea_op_e           op_i,
   input  mea_ew_e           ew_i,
   output logic [DATA_W-1:0] res_o,
   output logic              a_gt_b_o,
   output logic              a_lt_b_o
);
   localparam int QW  = DATA_W / 4;
   localparam int HW  = DATA_W / 2;
   localparam int SUM_W = DATA_W + 2;

   logic [SUM_W-1:0]  sum;
   logic [DATA_W:0]   diff;
   logic [DATA_W-1:0] raw_res;
   logic [DATA_W-1:0] mask;

   // carry-wide sum with rounding term; the shift drops bit 0
   assign sum = {ea_i[DATA_W], ea_i} + {eb_i[DATA_W], eb_i} + SUM_W'(1);

   assign a_gt_b_o = $signed(ea_i) > $signed(eb_i);
   assign a_lt_b_o = $signed(ea_i) < $signed(eb_i);

   assign diff = a_gt_b_o ? (ea_i - eb_i) : (eb_i - ea_i);

   always_comb begin
      case (op_i)
         OP_AVG:  raw_res = sum[DATA_W:1];
         OP_ABSD: raw_res = diff[DATA_W-1:0];
         OP_MIN:  raw_res = a_lt_b_o ? ea_i[DATA_W-1:0] : eb_i[DATA_W-1:0];
         default: raw_res = a_gt_b_o ? ea_i[DATA_W-1:0] : eb_i[DATA_W-1:0];
      endcase
   end

   always_comb begin
      case (ew_i)
         EW_QTR:  mask = {{(DATA_W-QW){1'b0}}, {QW{1'b1}}};
         EW_HALF: mask = {{(DATA_W-HW){1'b0}}, {HW{1'b1}}};
         default: mask = {DATA_W{1'b1}};
      endcase
   end

   assign res_o = raw_res & mask;
endmodule

// File: rtl/mea_flags.sv
module mea_flags
   import mea_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res_i,
   input  logic              a_gt_b_i,
   input  logic              a_lt_b_i,
   input  mea_op_e           op_i,
   input  mea_ew_e           ew_i,
   input  logic              sgn_i,
   input  logic              rec_i,
   output logic [COND_W-1:0] cond_o
);
   localparam int QW = DATA_W / 4;
   localparam int HW = DATA_W / 2;

   logic top_bit, neg, zero;
   logic lt, gt, eq;

   always_comb begin
      case (ew_i)
         EW_QTR:  top_bit = res_i[QW-1];
         EW_HALF: top_bit = res_i[HW-1];
         default: top_bit = res_i[DATA_W-1];
      endcase
   end

   assign neg  = sgn_i & top_bit;
   assign zero = (res_i == '0);

   always_comb begin
      if (op_i == OP_MIN || op_i == OP_MAX) begin
         // sign of b - a, taken from the operand comparison
         lt = a_gt_b_i;
         gt = a_lt_b_i;
         eq = ~a_gt_b_i & ~a_lt_b_i;
      end else begin
         lt = neg;
         gt = ~neg & ~zero;
         eq = zero;
      end
   end

   assign cond_o = rec_i ? {lt, gt, eq, 1'b0} : '0;
endmodule

// File: rtl/media_elem_alu.sv
module media_elem_alu
   import mea_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] op_a_i,
   input  logic [31:0] op_b_i,
   input  logic [1:0]  opcode_i,
   input  logic        signed_i,
   input  logic [1:0]  width_i,
   input  logic        rec_i,
   output logic [31:0] result_o,
   output logic [3:0]  cond_o
);
   localparam int QW = DATA_W / 4;
   localparam int HW = DATA_W / 2;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("media_elem_alu: DATA_W must match the 32-bit port width");
      end
      if (COND_W != 4) begin : g_bad_cond
         $error("media_elem_alu: condition field must be 4 bits");
      end
   endgenerate

   mea_op_e           op;
   mea_ew_e           ew;
   logic [DATA_W:0]   ext_a, ext_b;
   logic [DATA_W-1:0] core_res;
   logic [COND_W-1:0] core_cond;
   logic              a_gt_b, a_lt_b;

   assign op = mea_op_e'(opcode_i);
   assign ew = mea_ew_e'(width_i);

   mea_operand #(.DATA_W(DATA_W)) u_ext_a (
      .raw_i(op_a_i), .ew_i(ew), .sgn_i(signed_i), .ext_o(ext_a)
   );

   mea_operand #(.DATA_W(DATA_W)) u_ext_b (
      .raw_i(op_b_i), .ew_i(ew), .sgn_i(signed_i), .ext_o(ext_b)
   );

   mea_arith #(.DATA_W(DATA_W)) u_arith (
      .ea_i(ext_a), .eb_i(ext_b), .op_i(op), .ew_i(ew),
      .res_o(core_res), .a_gt_b_o(a_gt_b), .a_lt_b_o(a_lt_b)
   );

   mea_flags #(.DATA_W(DATA_W)) u_flags (
      .res_i(core_res), .a_gt_b_i(a_gt_b), .a_lt_b_i(a_lt_b),
      .op_i(op), .ew_i(ew), .sgn_i(signed_i), .rec_i(rec_i),
      .cond_o(core_cond)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic [DATA_W-1:0] res_q;
         logic [COND_W-1:0] cond_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               res_q  <= '0;
               cond_q <= '0;
            end else begin
               res_q  <= core_res;
               cond_q <= core_cond;
            end
         end
         assign result_o = res_q;
         assign cond_o   = cond_q;
      end else begin : g_comb
         assign result_o = core_res;
         assign cond_o   = core_cond;
      end
   endgenerate

   // ---------------- assertions ----------------
   logic [DATA_W-1:0] chk_mask;
   always_comb begin
      case (width_i)
         2'd0:    chk_mask = (DATA_W)'((64'd1 << QW) - 64'd1);
         2'd1:    chk_mask = (DATA_W)'((64'd1 << HW) - 64'd1);
         default: chk_mask = {DATA_W{1'b1}};
      endcase
   end

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (core_res & ~chk_mask) == '0);                                  // R6

   AST_NOREC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_i |-> core_cond == '0);                                     // R7

   AST_SO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      core_cond[0] == 1'b0);                                           // R10

   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rec_i |-> $countones(core_cond[3:1]) == 1);                      // R10

   AST_MINMAX_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      opcode_i[1] |-> (core_res == (op_a_i & chk_mask) ||
                       core_res == (op_b_i & chk_mask)));              // R3

   AST_MINMAX_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode_i[1] && rec_i && core_cond[1]) |->
         (op_a_i & chk_mask) == (op_b_i & chk_mask));                  // R8

   generate
      if (REG_OUT) begin : g_lat_chk
         AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |=> result_o == $past(core_res));             // R11
      end
   endgenerate
endmodule

// File: tb/media_elem_alu_bench.sv
module media_elem_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] op_a, op_b;
   logic [1:0]  opcode;
   logic        sgn;
   logic [1:0]  wsel;
   logic        rec;
   logic [31:0] result;
   logic [3:0]  cond;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [31:0] exp_res, prev_res;
   logic [3:0]  exp_cond, prev_cond;

   always #5 clk = ~clk;

   media_elem_alu u_media_elem_alu (
      .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b),
      .opcode_i(opcode), .signed_i(sgn), .width_i(wsel), .rec_i(rec),
      .result_o(result), .cond_o(cond)
   );

   function automatic int wbits(logic [1:0] w);
      return (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
   endfunction

   function automatic longint elem(logic [31:0] v, int w, bit s);
      longint m = (longint'(1) << w) - 1;
      longint x = longint'(v) & m;
      if (s && x[w-1]) x = x - (longint'(1) << w);
      return x;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string op_req(logic [1:0] o);
      case (o)
         2'd0: return "R1 average";
         2'd1: return "R2 absdiff";
         2'd2: return "R3 min";
         default: return "R4 max";
      endcase
   endfunction

   // behavioural reference
   task automatic model(input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] o, input bit s,
                        input logic [1:0] w, input bit r);
      int     wb = wbits(w);
      longint m  = (longint'(1) << wb) - 1;
      longint ea = elem(a, wb, s);
      longint eb = elem(b, wb, s);
      longint rv;
      logic [31:0] rr;
      bit neg;
      case (o)
         2'd0: rv = (ea + eb + 1) >>> 1;
         2'd1: rv = (ea > eb) ? ea - eb : eb - ea;
         2'd2: rv = (ea < eb) ? ea : eb;
         default: rv = (ea > eb) ? ea : eb;
      endcase
      rr = 32'(rv & m);
      exp_res = rr;
      if (!r) exp_cond = 4'b0000;
      else if (o[1]) exp_cond = {eb < ea, eb > ea, eb == ea, 1'b0};
      else begin
         neg = s && rr[wb-1];
         exp_cond = {neg, !neg && rr != 0, rr == 0, 1'b0};
      end
   endtask

   task automatic run(input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] o, input bit s,
                      input logic [1:0] w, input bit r);
      int wb = wbits(w);
      logic [31:0] upper = (wb == 32) ? 32'h0 : ~((32'h1 << wb) - 32'h1);
      prev_res  = exp_res;
      prev_cond = exp_cond;
      op_a = a; op_b = b; opcode = o; sgn = s; wsel = w; rec = r;
      model(a, b, o, s, w, r);
      #1;
      chk(result == prev_res && cond == prev_cond, "R11 registered latency",
          {result[31:4], cond}, {prev_res[31:4], prev_cond});
      @(negedge clk);
      chk(result == exp_res, op_req(o), result, exp_res);
      chk((result & upper) == 0, "R6 upper bits", result, 32'(exp_res & upper));
      if (!r)
         chk(cond == exp_cond, "R7 cond cleared", 32'(cond), 32'(exp_cond));
      else if (o[1])
         chk(cond == exp_cond, "R8 minmax cond", 32'(cond), 32'(exp_cond));
      else
         chk(cond == exp_cond, "R9 result cond", 32'(cond), 32'(exp_cond));
      chk(cond[0] == 1'b0, "R10 SO bit", 32'(cond), 32'(exp_cond));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678;
      opcode = 2'd3; sgn = 1'b1; wsel = 2'd2; rec = 1'b1;
      repeat (3) @(negedge clk);
      chk(result == 0 && cond == 0, "R11 reset state", {result[31:4], cond}, 32'h0);
      rst_n = 1'b1;
      exp_res = 32'h0; exp_cond = 4'h0;
      // first cycle after reset: capture happens at the next edge
      op_a = 0; op_b = 0; opcode = 0; sgn = 0; wsel = 0; rec = 0;
      @(negedge clk);

      // R1: carry retained, unsigned and signed extremes, rounding up
      run(32'h0000_00FF, 32'h0000_00FF, 2'd0, 1'b0, 2'd0, 1'b1);
      run(32'h0000_0080, 32'h0000_0080, 2'd0, 1'b1, 2'd0, 1'b1);
      run(32'h0000_0003, 32'h0000_0004, 2'd0, 1'b0, 2'd0, 1'b1);
      run(32'hFFFF_FFFF, 32'hFFFF_FFFE, 2'd0, 1'b1, 2'd0, 1'b1);
      run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 1'b0, 2'd2, 1'b1);
      run(32'h8000_0000, 32'h8000_0000, 2'd0, 1'b1, 2'd3, 1'b1);
      // R2: both orderings, signed wrap
      run(32'h0000_0010, 32'h0000_0003, 2'd1, 1'b0, 2'd1, 1'b1);
      run(32'h0000_0003, 32'h0000_0010, 2'd1, 1'b0, 2'd1, 1'b1);
      run(32'h0000_0080, 32'h0000_007F, 2'd1, 1'b1, 2'd0, 1'b1);
      run(32'h0000_0005, 32'h0000_0005, 2'd1, 1'b1, 2'd0, 1'b1);
      // R3 R4 R5: signedness flips the order; upper garbage ignored
      run(32'hAB00_0080, 32'hCD00_0001, 2'd2, 1'b1, 2'd0, 1'b1);
      run(32'hAB00_0080, 32'hCD00_0001, 2'd2, 1'b0, 2'd0, 1'b1);
      run(32'h1234_8000, 32'h5678_7FFF, 2'd3, 1'b1, 2'd1, 1'b1);
      run(32'h1234_8000, 32'h5678_7FFF, 2'd3, 1'b0, 2'd1, 1'b1);
      // R8: equal operands, and cond reflects b-a not the returned value
      run(32'h0000_1234, 32'hFFFF_1234, 2'd3, 1'b0, 2'd1, 1'b1);
      run(32'h0000_0009, 32'h0000_0002, 2'd2, 1'b0, 2'd0, 1'b1);
      run(32'h0000_0009, 32'h0000_0002, 2'd3, 1'b0, 2'd0, 1'b1);
      // R7: record off
      run(32'h0000_0001, 32'h0000_0002, 2'd3, 1'b0, 2'd0, 1'b0);

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a = $urandom;
         logic [31:0] b = ($urandom_range(0, 7) == 0) ? a : $urandom;
         run(a, b, 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule